// File: doc/BRIEF.md
# Static Memory Bank Timing Sequencer

This block runs single read and write accesses to an external asynchronous static memory divided into six chip-select banks. A requester presents a bank number, a word address, a direction and write data. While the sequencer is idle the request is accepted. The sequencer then drives one bank select, the output enable or the write enable, the address and the write data for as many cycles as the bank's timing settings call for. It returns read data together with a one-cycle done pulse.

Each bank has three settings, loaded over a small register bus:
- a turnaround count of idle cycles, inserted only when the data bus changes direction between consecutive accesses;
- a read wait count, which lengthens each read;
- a burst-ROM flag. With the flag set, a read that continues a sequential run within the same bank completes without wait states.

A single extension input from the memory side can also lengthen the final access cycle.

Settings are captured when a request is accepted. A register write therefore governs every access accepted after it. The reset input is asynchronous and active low, and its release is synchronised inside the block.

Top module: `smc_bank_seq`

## Requirements
- R1: After reset, every bank reads back turnaround 15, read wait 31 and burst flag 0. done is low, req_ready is high and all six bank selects are high.
- R2: Register address `{bank[2:0], slot[2:0], 2'b00}` selects a bank group with a stride of 0x20. Slot 0 holds the turnaround field, in data bits [3:0]. Slot 1 holds the read wait field, in bits [4:0]. Slot 2 holds the burst flag, in bit 0, where 1 means burst ROM. Data bits above a field are dropped on write and read back as 0. Writes to bank 6 or 7, to slots 3 to 7, or to unaligned addresses change no setting, and those addresses read as 0.
- R3: A read with no turnaround on a bank with burst flag 0 raises done exactly W+1 clock edges after the accepting edge, where W is that bank's read wait count. This holds for W = 0 and for sequential addresses.
- R4: When an access is in the opposite direction to the previous accepted access, T idle cycles are inserted before it. T is the accessed bank's turnaround count, and all selects and strobes stay high during those cycles. Same-direction accesses, a count of 0, and the first access after reset insert none.
- R5: A write holds its access for one cycle plus any turnaround. During that cycle we_n is low, oe_n is high, mem_dout_en is high and mem_dout carries the write data.
- R6: On a bank with the burst flag set, a read that has the same bank as the previous accepted access, an address equal to the previous address plus 1, and a previous access that was a burst-bank read completes with zero wait states. A non-sequential address, a different bank or an intervening write makes the next read take the full wait count.
- R7: During the access phase, exactly the addressed bank's select is low and mem_addr carries the request address. oe_n is low for a read and we_n is low for a write, and the two strobes are never low together.
- R8: done is a single-cycle pulse. In the cycle done is high, rd_data equals mem_din as sampled at the clock edge that ends the final access cycle of a read.
- R9: req_ready is high only while idle. A request presented while busy is ignored and produces neither a done pulse nor a bus access.
- R10: While mem_wait is high in the final access cycle, the access is held. Done comes one edge after the first final-cycle edge at which mem_wait is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte address |
| cfg_wdata | input | 5 | Register write data |
| cfg_rdata | output | 5 | Register read data, combinational from cfg_addr |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 3 | Target bank, 0 to 5 |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Sequencer idle, a request is accepted |
| mem_cs_n | output | 6 | Active-low bank selects |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_addr | output | 16 | Memory address |
| mem_dout | output | 16 | Write data to memory |
| mem_dout_en | output | 1 | Data bus drive enable |
| mem_din | input | 16 | Read data from memory |
| mem_wait | input | 1 | Extends the final access cycle |
| rd_data | output | 16 | Captured read data |
| done | output | 1 | Access completion pulse |

## Verification
The hardest situation to reach is the zero-wait continuation read. It needs a burst-flagged bank, an unbroken history of reads on that bank with strictly incrementing addresses, and no write or bank change in between. Turnaround also depends on the direction of the previous access. The bench therefore keeps its own running model of the last direction, bank, address and burst state, and it builds chains of reads that it deliberately breaks by an address skip, a visit to another bank or a write. Each break is followed by a read whose expected full wait count comes from that model.

// File: rtl/smc_pkg.sv
package smc_pkg;
  localparam int NBANK_DEF  = 6;
  localparam int IDCY_W_DEF = 4;
  localparam int WST_W_DEF  = 5;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TURN = 2'd1,
    ST_ACC  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/smc_cfg_regs.sv
module smc_cfg_regs #(
  parameter int NBANK  = 6,
  parameter int BANK_W = 3,
  parameter int IDCY_W = 4,
  parameter int WST_W  = 5,
  parameter int CFG_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [WST_W-1:0]  cfg_wdata,
  output logic [WST_W-1:0]  cfg_rdata,
  input  logic [BANK_W-1:0] sel_bank,
  output logic [IDCY_W-1:0] sel_idcy,
  output logic [WST_W-1:0]  sel_wst,
  output logic              sel_burst
);
  localparam int GRP_W = CFG_AW - 5;
  localparam logic [IDCY_W-1:0] IDCY_RST = '1;
  localparam logic [WST_W-1:0]  WST_RST  = '1;

  logic [IDCY_W-1:0] idcy_q  [NBANK];
  logic [WST_W-1:0]  wst_q   [NBANK];
  logic              burst_q [NBANK];

  logic [GRP_W-1:0] grp;
  logic [2:0]       slot;
  logic             aligned;
  logic [NBANK-1:0] wr_idcy, wr_wst, wr_burst;

  assign grp     = cfg_addr[CFG_AW-1:5];
  assign slot    = cfg_addr[4:2];
  assign aligned = (cfg_addr[1:0] == 2'b00);

  for (genvar g = 0; g < NBANK; g++) begin : g_dec
    logic hit;
    assign hit         = cfg_we && aligned && (grp == GRP_W'(g));
    assign wr_idcy[g]  = hit && (slot == 3'd0);
    assign wr_wst[g]   = hit && (slot == 3'd1);
    assign wr_burst[g] = hit && (slot == 3'd2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NBANK; b++) begin
        idcy_q[b]  <= IDCY_RST;
        wst_q[b]   <= WST_RST;
        burst_q[b] <= 1'b0;
      end
    end else begin
      for (int b = 0; b < NBANK; b++) begin
        if (wr_idcy[b])  idcy_q[b]  <= cfg_wdata[IDCY_W-1:0];
        if (wr_wst[b])   wst_q[b]   <= cfg_wdata;
        if (wr_burst[b]) burst_q[b] <= cfg_wdata[0];
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (aligned && (grp == GRP_W'(b))) begin
        case (slot)
          3'd0:    cfg_rdata[IDCY_W-1:0] = idcy_q[b];
          3'd1:    cfg_rdata = wst_q[b];
          3'd2:    cfg_rdata[0] = burst_q[b];
          default: cfg_rdata = '0;
        endcase
      end
    end
  end

  always_comb begin
    sel_idcy  = '0;
    sel_wst   = '0;
    sel_burst = 1'b0;
    for (int b = 0; b < NBANK; b++) begin
      if (sel_bank == BANK_W'(b)) begin
        sel_idcy  = idcy_q[b];
        sel_wst   = wst_q[b];
        sel_burst = burst_q[b];
      end
    end
  end
endmodule

// File: rtl/smc_dir_track.sv
module smc_dir_track #(
  parameter int IDCY_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_write,
  input  logic [IDCY_W-1:0] idcy,
  output logic [IDCY_W-1:0] turn_cycles
);
  logic have_prev_q, have_prev_d;
  logic last_wr_q, last_wr_d;

  always_comb begin
    have_prev_d = have_prev_q;
    last_wr_d   = last_wr_q;
    if (acc_en) begin
      have_prev_d = 1'b1;
      last_wr_d   = acc_write;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_prev_q <= 1'b0;
      last_wr_q   <= 1'b0;
    end else begin
      have_prev_q <= have_prev_d;
      last_wr_q   <= last_wr_d;
    end
  end

  assign turn_cycles = (have_prev_q && (last_wr_q != acc_write)) ? idcy : '0;
endmodule

// File: rtl/smc_burst_track.sv
module smc_burst_track #(
  parameter int ADDR_W = 16,
  parameter int BANK_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_write,
  input  logic [BANK_W-1:0] acc_bank,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              bank_burst,
  output logic              continues
);
  logic              live_q, live_d;
  logic [BANK_W-1:0] bank_q, bank_d;
  logic [ADDR_W-1:0] addr_q, addr_d;

  always_comb begin
    live_d = live_q;
    bank_d = bank_q;
    addr_d = addr_q;
    if (acc_en) begin
      live_d = !acc_write && bank_burst;
      bank_d = acc_bank;
      addr_d = acc_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      bank_q <= '0;
      addr_q <= '0;
    end else begin
      live_q <= live_d;
      bank_q <= bank_d;
      addr_q <= addr_d;
    end
  end

  assign continues = !acc_write && bank_burst && live_q &&
                     (bank_q == acc_bank) &&
                     (acc_addr == addr_q + ADDR_W'(1));
endmodule

// File: rtl/smc_bank_seq.sv
module smc_bank_seq
  import smc_pkg::*;
#(
  parameter int NBANK  = NBANK_DEF,
  parameter int IDCY_W = IDCY_W_DEF,
  parameter int WST_W  = WST_W_DEF,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CFG_AW = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [CFG_AW-1:0]        cfg_addr,
  input  logic [WST_W-1:0]         cfg_wdata,
  output logic [WST_W-1:0]         cfg_rdata,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic [$clog2(NBANK)-1:0] req_bank,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     req_ready,
  output logic [NBANK-1:0]         mem_cs_n,
  output logic                     mem_oe_n,
  output logic                     mem_we_n,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [DATA_W-1:0]        mem_dout,
  output logic                     mem_dout_en,
  input  logic [DATA_W-1:0]        mem_din,
  input  logic                     mem_wait,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     done
);
  localparam int BANK_W = $clog2(NBANK);
  localparam int CNT_W  = (WST_W > IDCY_W) ? WST_W : IDCY_W;

  // reset release synchroniser
  logic [1:0] rst_pipe;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  seq_state_e        st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CNT_W-1:0]  wait_q;
  logic              wr_q;
  logic [BANK_W-1:0] bank_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rd_q;
  logic              done_q, done_d;
  logic              load, capture;

  logic [IDCY_W-1:0] sel_idcy, turn_cycles;
  logic [WST_W-1:0]  sel_wst;
  logic              sel_burst, continues;
  logic [CNT_W-1:0]  wait_eff;

  smc_cfg_regs #(
    .NBANK(NBANK), .BANK_W(BANK_W), .IDCY_W(IDCY_W),
    .WST_W(WST_W), .CFG_AW(CFG_AW)
  ) u_regs (
    .clk(clk), .rst_n(rst_n_s), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .sel_bank(req_bank),
    .sel_idcy(sel_idcy), .sel_wst(sel_wst), .sel_burst(sel_burst)
  );

  smc_dir_track #(.IDCY_W(IDCY_W)) u_dir (
    .clk(clk), .rst_n(rst_n_s), .acc_en(load), .acc_write(req_write),
    .idcy(sel_idcy), .turn_cycles(turn_cycles)
  );

  smc_burst_track #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_burst (
    .clk(clk), .rst_n(rst_n_s), .acc_en(load), .acc_write(req_write),
    .acc_bank(req_bank), .acc_addr(req_addr), .bank_burst(sel_burst),
    .continues(continues)
  );

  assign wait_eff = (req_write || continues) ? '0 : CNT_W'(sel_wst);

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    load    = 1'b0;
    capture = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req_valid && rst_n_s) begin
          load = 1'b1;
          if (turn_cycles != '0) begin
            st_d  = ST_TURN;
            cnt_d = CNT_W'(turn_cycles) - CNT_W'(1);
          end else begin
            st_d  = ST_ACC;
            cnt_d = wait_eff;
          end
        end
      end
      ST_TURN: begin
        if (cnt_q == '0) begin
          st_d  = ST_ACC;
          cnt_d = wait_q;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      ST_ACC: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - CNT_W'(1);
        end else if (!mem_wait) begin
          st_d    = ST_IDLE;
          done_d  = 1'b1;
          capture = !wr_q;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      wait_q  <= '0;
      wr_q    <= 1'b0;
      bank_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rd_q    <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
      if (load) begin
        wait_q  <= wait_eff;
        wr_q    <= req_write;
        bank_q  <= req_bank;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (capture) rd_q <= mem_din;
    end
  end

  logic in_acc;
  assign in_acc = (st_q == ST_ACC);

  for (genvar b = 0; b < NBANK; b++) begin : g_cs
    assign mem_cs_n[b] = !(in_acc && (bank_q == BANK_W'(b)));
  end

  assign req_ready   = (st_q == ST_IDLE) && rst_n_s;
  assign mem_oe_n    = !(in_acc && !wr_q);
  assign mem_we_n    = !(in_acc && wr_q);
  assign mem_dout_en = in_acc && wr_q;
  assign mem_addr    = addr_q;
  assign mem_dout    = wdata_q;
  assign rd_data     = rd_q;
  assign done        = done_q;
endmodule

// File: rtl/smc_bank_seq_chk.sv
module smc_bank_seq_chk #(
  parameter int NBANK = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [NBANK-1:0] mem_cs_n,
  input logic             mem_oe_n,
  input logic             mem_we_n,
  input logic             mem_dout_en,
  input logic             mem_wait,
  input logic             done
);
  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cs_n)); // R7
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n)); // R7
  AST_STROBE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n || !mem_we_n) |-> (mem_cs_n != '1)); // R7
  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dout_en |-> (mem_oe_n && !mem_we_n)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R9
  AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready); // R9
  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_cs_n != '1) && mem_wait) |=> !done); // R10
endmodule

bind smc_bank_seq smc_bank_seq_chk #(.NBANK(NBANK)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
  .mem_dout_en(mem_dout_en), .mem_wait(mem_wait), .done(done)
);

// File: tb/tb_smc_bank_seq.sv
module tb_smc_bank_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [7:0]  cfg_addr;
  logic [4:0]  cfg_wdata;
  logic [4:0]  cfg_rdata;
  logic        req_valid, req_write;
  logic [2:0]  req_bank;
  logic [15:0] req_addr, req_wdata;
  logic        req_ready;
  logic [5:0]  mem_cs_n;
  logic        mem_oe_n, mem_we_n, mem_dout_en, mem_wait;
  logic [15:0] mem_addr, mem_dout, mem_din, rd_data;
  logic        done;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;

  int sh_idle [6];
  int sh_wait [6];
  int sh_mode [6];
  bit m_have_prev = 0;
  bit m_last_wr = 0;
  bit m_live = 0;
  int m_lbank = 0;
  int m_laddr = 0;

  smc_bank_seq dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_write(req_write), .req_bank(req_bank), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .mem_cs_n(mem_cs_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
    .mem_dout(mem_dout), .mem_dout_en(mem_dout_en), .mem_din(mem_din),
    .mem_wait(mem_wait), .rd_data(rd_data), .done(done)
  );

  assign mem_din = mem_addr ^ 16'h5A3C;

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        nchk++;
        nfail++;
        $display("FAIL watchdog act=%0d exp=<150000", cyc);
        summary();
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input int addr, input int data);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_addr  = addr[7:0];
    cfg_wdata = data[4:0];
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input int addr, output int data);
    cfg_addr = addr[7:0];
    #1;
    data = int'(cfg_rdata);
  endtask

  task automatic set_bank(input int b, input int idle, input int wt, input int mode);
    cfg_write(b * 32 + 0, idle);
    cfg_write(b * 32 + 4, wt);
    cfg_write(b * 32 + 8, mode);
    sh_idle[b] = idle;
    sh_wait[b] = wt;
    sh_mode[b] = mode;
  endtask

  task automatic do_access(input bit wr, input int bank, input int addr, input int wdata,
                           input int release_at, input bit intrude, input string tag);
    int t, w, lat, cnt, acc, bad, extra;
    bit cont;
    t = (m_have_prev && (m_last_wr != wr)) ? sh_idle[bank] : 0;
    cont = !wr && (sh_mode[bank] != 0) && m_live && (m_lbank == bank) &&
           (addr == ((m_laddr + 1) & 16'hFFFF));
    w = (wr || cont) ? 0 : sh_wait[bank];
    lat = t + w + 1;
    if (release_at >= 0 && release_at > t + w) lat = release_at + 1;
    m_have_prev = 1;
    m_last_wr   = wr;
    m_live      = !wr && (sh_mode[bank] != 0);
    m_lbank     = bank;
    m_laddr     = addr;

    @(negedge clk);
    check(req_ready == 1'b1, {tag, " R9 ready before request"}, int'(req_ready), 1);
    req_valid = 1'b1;
    req_write = wr;
    req_bank  = bank[2:0];
    req_addr  = addr[15:0];
    req_wdata = wdata[15:0];
    if (release_at >= 0) mem_wait = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    cnt = 0; acc = 0; bad = 0;
    while (!done && cnt < 400) begin
      if (release_at >= 0 && cnt == release_at) mem_wait = 1'b0;
      if (mem_cs_n != 6'h3F) begin
        acc++;
        if (mem_cs_n != ~(6'b1 << bank)) bad++;
        if (mem_addr != addr[15:0]) bad++;
        if (wr) begin
          if (mem_we_n || !mem_oe_n || !mem_dout_en || mem_dout != wdata[15:0]) bad++;
        end else begin
          if (mem_oe_n || !mem_we_n || mem_dout_en) bad++;
        end
      end else if (!mem_oe_n || !mem_we_n || mem_dout_en) begin
        bad++;
      end
      if (req_ready) bad++;
      if (intrude && cnt == 1) begin
        req_valid = 1'b1;
        req_write = !wr;
        req_bank  = 3'((bank + 1) % 6);
      end
      if (intrude && cnt == 2) req_valid = 1'b0;
      @(negedge clk);
      cnt++;
    end
    mem_wait = 1'b0;
    check(cnt == lat, {tag, " latency"}, cnt, lat);
    check(acc == lat - t, {tag, " R7 access cycles"}, acc, lat - t);
    check(bad == 0, {tag, " R7 strobes/R9 busy"}, bad, 0);
    if (!wr) check(rd_data == (addr[15:0] ^ 16'h5A3C), {tag, " R8 read data"},
                   int'(rd_data), int'(addr[15:0] ^ 16'h5A3C));
    @(negedge clk);
    check(done == 1'b0, {tag, " R8 single pulse"}, int'(done), 0);
    if (intrude) begin
      extra = 0;
      for (int i = 0; i < 6; i++) begin
        if (done || !req_ready || mem_cs_n != 6'h3F) extra++;
        @(negedge clk);
      end
      check(extra == 0, "R9 busy request ignored", extra, 0);
    end
  endtask

  initial begin
    int v;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    req_valid = 1'b0; req_write = 1'b0; req_bank = '0; req_addr = '0;
    req_wdata = '0; mem_wait = 1'b0;
    for (int b = 0; b < 6; b++) begin
      sh_idle[b] = 15; sh_wait[b] = 31; sh_mode[b] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(done == 1'b0, "R1 done after reset", int'(done), 0);
    check(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    check(mem_cs_n == 6'h3F, "R1 selects after reset", int'(mem_cs_n), 63);
    for (int b = 0; b < 6; b++) begin
      cfg_read(b * 32 + 0, v); check(v == 15, "R1 idle reset", v, 15);
      cfg_read(b * 32 + 4, v); check(v == 31, "R1 wait reset", v, 31);
      cfg_read(b * 32 + 8, v); check(v == 0,  "R1 mode reset", v, 0);
    end

    // R2 field masking and ignored addresses
    cfg_write(32 + 0, 5'h15); sh_idle[1] = 5;
    cfg_read(32 + 0, v); check(v == 5, "R2 idle upper bits dropped", v, 5);
    cfg_write(32 + 4, 3); sh_wait[1] = 3;
    cfg_read(32 + 4, v); check(v == 3, "R2 wait field", v, 3);
    cfg_write(32 + 8, 5'h1E);
    cfg_read(32 + 8, v); check(v == 0, "R2 mode bit0 only", v, 0);
    cfg_write(6 * 32 + 0, 2);
    cfg_write(7 * 32 + 4, 2);
    cfg_write(0 * 32 + 12, 1);
    cfg_write(0 * 32 + 1, 1);
    for (int b = 0; b < 6; b++) begin
      cfg_read(b * 32 + 0, v);
      check(v == sh_idle[b], "R2 ignored write idle", v, sh_idle[b]);
      cfg_read(b * 32 + 4, v);
      check(v == sh_wait[b], "R2 ignored write wait", v, sh_wait[b]);
    end
    cfg_read(6 * 32 + 0, v); check(v == 0, "R2 bank6 reads zero", v, 0);
    cfg_read(0 * 32 + 12, v); check(v == 0, "R2 slot3 reads zero", v, 0);

    // R3 read wait sweep, sequential addresses on non-burst banks
    for (int b = 0; b < 6; b++) begin
      for (int k = 0; k < 5; k++) begin
        int wv;
        wv = (k == 4) ? 9 : k * 2 - (k == 3 ? 1 : 0);
        set_bank(b, 3, wv, 0);
        do_access(1'b0, b, b * 32 + k, 0, -1, 1'b0, "R3");
      end
    end

    // R4 turnaround sweep with direction patterns
    for (int t = 0; t < 4; t++) begin
      set_bank(2, t, 1, 0);
      do_access(1'b1, 2, 16'h200 + t, 16'hA000 + t, -1, 1'b0, "R4");
      do_access(1'b1, 2, 16'h210 + t, 16'hB000 + t, -1, 1'b0, "R4");
      do_access(1'b0, 2, 16'h220 + t, 0, -1, 1'b0, "R4");
      do_access(1'b0, 2, 16'h230 + t, 0, -1, 1'b0, "R4");
      do_access(1'b1, 2, 16'h240 + t, 16'hC000 + t, -1, 1'b0, "R4");
    end

    // R5 writes on every bank
    for (int b = 0; b < 6; b++) begin
      set_bank(b, b % 3, 7, 0);
      do_access(1'b1, b, 16'h300 + b, 16'h1234 * (b + 1), -1, 1'b0, "R5");
    end

    // R6 burst ROM runs and breaks
    set_bank(3, 0, 4, 1);
    set_bank(4, 0, 2, 1);
    do_access(1'b0, 3, 100, 0, -1, 1'b0, "R6 first");
    do_access(1'b0, 3, 101, 0, -1, 1'b0, "R6 cont");
    do_access(1'b0, 3, 102, 0, -1, 1'b0, "R6 cont");
    do_access(1'b0, 3, 104, 0, -1, 1'b0, "R6 skip");
    do_access(1'b0, 3, 105, 0, -1, 1'b0, "R6 cont");
    do_access(1'b0, 4, 106, 0, -1, 1'b0, "R6 bank switch");
    do_access(1'b0, 3, 106, 0, -1, 1'b0, "R6 back");
    do_access(1'b0, 3, 107, 0, -1, 1'b0, "R6 cont");
    do_access(1'b1, 3, 108, 16'h7777, -1, 1'b0, "R6 write");
    do_access(1'b0, 3, 109, 0, -1, 1'b0, "R6 after write");
    do_access(1'b0, 3, 16'hFFFF, 0, -1, 1'b0, "R6 nonseq");
    do_access(1'b0, 3, 16'h0000, 0, -1, 1'b0, "R6 wrap cont");

    // R10 wait extension
    set_bank(0, 1, 2, 0);
    do_access(1'b1, 0, 16'h400, 16'h4242, 6, 1'b0, "R10 write held");
    do_access(1'b0, 0, 16'h401, 0, 7, 1'b0, "R10 read held");
    do_access(1'b0, 0, 16'h402, 0, 1, 1'b0, "R10 early release");

    // R9 request while busy
    set_bank(5, 0, 6, 0);
    do_access(1'b0, 5, 16'h500, 0, -1, 1'b1, "R9");

    summary();
  end
endmodule